// File: doc/BRIEF.md
# Clock Generator Configuration Target (I2C block write)

This block is the configuration port of a clock generator. It behaves as a write-only I2C target and holds a small bank of 8-bit control registers. The bits of these registers gate individual clock outputs and carry frequency-select fields. Every write follows one fixed framing. The device address comes first. A command byte and a byte-count byte follow, and the target acknowledges both and then drops them. After that, data bytes fill the bank from register 0 upward, with no sub-address.

SDA and SCL are modelled as open-drain lines, with a separate input, output value and output enable for each. Both lines are synchronised into the faster system clock. START and STOP are recognised as SDA edges that occur while SCL is high. The registers return to their default values only on the power-on reset. That reset also samples the hardware frequency-select straps into a latch that stays fixed for the rest of the run.

Top module: `clkcfg_i2c_target`

## Requirements
- R1: While `por_n` is low and after it rises, `cfg_regs` equals the `RESET_VALUE` parameter, and `sda_oe` is low. Register k occupies bits [8k+7:8k] of both vectors.
- R2: An address byte whose upper seven bits equal `DEV_ADDR` and whose last bit (the R/W bit, 0 = write) is 0 gets an acknowledge. Bits are sent MSB first.
- R3: An address byte that does not match, or that has the R/W bit set to 1, gets no acknowledge. No byte that follows it, up to the next START, is acknowledged or changes any register.
- R4: The first byte after an accepted address is acknowledged, and its value has no effect on any register.
- R5: The second byte after an accepted address is acknowledged, and its value has no effect on any register.
- R6: The third and later bytes of a transaction are written, MSB first, to register 0, then register 1, and so on, one register per byte.
- R7: Data bytes beyond register `NUM_REGS-1` are acknowledged and discarded, and every implemented register keeps its value.
- R8: Every START, including a repeated START, restarts the register index at 0.
- R9: A STOP or START that arrives in the middle of a byte drops the partial byte. Registers written earlier in the same transaction keep their new values.
- R10: `strap_q` follows `strap_i` while `por_n` is low. It holds the value from the last reset cycle for as long as `por_n` stays high.
- R11: `sda_oe` rises only after the SCL falling edge that ends the eighth bit of an acknowledged byte. It falls again after the next SCL falling edge, so it is low during every data-bit SCL high period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| por_n | input | 1 | Power-on reset, active low, synchronous |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_o | output | 1 | SDA drive value, constant 0 |
| sda_oe | output | 1 | SDA pull-down enable (acknowledge) |
| strap_i | input | STRAP_W | Frequency-select strap pin levels |
| strap_q | output | STRAP_W | Straps latched during power-on reset |
| cfg_regs | output | 8*NUM_REGS | Control register bank, register k at [8k+7:8k] |

## Verification
The assertions assume that SCL is much slower than `clk`, so that every SCL high and low phase, and every SDA setup before an SCL edge, lasts several system cycles longer than the synchroniser delay. They also assume that SDA changes while SCL is high only to form a START or a STOP. The bench drives the bus with fixed quarter and half periods of 8 and 16 system cycles. It moves SDA only while SCL is low, except inside its own START and STOP tasks. Random transactions vary the command, count and data values, the payload length up to two bytes past the bank, and the address, including the R/W bit.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;
   localparam int ADDR_BITS = 7;
   localparam int BYTE_BITS = 8;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_ADDR,
      PH_CMD,
      PH_COUNT,
      PH_DATA,
      PH_SKIP
   } phase_e;
endpackage

// File: rtl/clkcfg_line_sync.sv
module clkcfg_line_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic por_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic bus_start,
   output logic bus_stop
);
   logic [SYNC_STAGES-1:0] scl_chain, sda_chain;
   logic                   scl_d, sda_d;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_stages
         $error("clkcfg_line_sync: SYNC_STAGES must be at least 2");
      end
      for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!por_n) begin
                  scl_chain[0] <= 1'b1;
                  sda_chain[0] <= 1'b1;
               end else begin
                  scl_chain[0] <= scl_i;
                  sda_chain[0] <= sda_i;
               end
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!por_n) begin
                  scl_chain[s] <= 1'b1;
                  sda_chain[s] <= 1'b1;
               end else begin
                  scl_chain[s] <= scl_chain[s-1];
                  sda_chain[s] <= sda_chain[s-1];
               end
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!por_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_chain[SYNC_STAGES-1];
         sda_d <= sda_chain[SYNC_STAGES-1];
      end
   end

   assign sda_s     = sda_chain[SYNC_STAGES-1];
   assign scl_rise  = scl_chain[SYNC_STAGES-1] & ~scl_d;
   assign scl_fall  = ~scl_chain[SYNC_STAGES-1] & scl_d;
   assign bus_start = scl_chain[SYNC_STAGES-1] & scl_d & sda_d & ~sda_s;
   assign bus_stop  = scl_chain[SYNC_STAGES-1] & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/clkcfg_byte_engine.sv
module clkcfg_byte_engine
   import clkcfg_pkg::*;
#(
   parameter logic [ADDR_BITS-1:0] DEV_ADDR = 7'h69,
   parameter int NUM_REGS = 6,
   parameter int IDX_W    = $clog2(NUM_REGS + 1)
) (
   input  logic                 clk,
   input  logic                 por_n,
   input  logic                 sda_s,
   input  logic                 scl_rise,
   input  logic                 scl_fall,
   input  logic                 bus_start,
   input  logic                 bus_stop,
   output logic                 ack_drv,
   output logic                 wr_en,
   output logic [IDX_W-1:0]     wr_idx,
   output logic [BYTE_BITS-1:0] wr_data
);
   localparam logic [IDX_W-1:0] IDX_END = IDX_W'(NUM_REGS);

   phase_e               phase;
   logic [3:0]           bit_cnt;
   logic                 in_ack;
   logic [BYTE_BITS-1:0] shreg;
   logic [IDX_W-1:0]     idx;
   logic                 active;

   assign active = (phase != PH_IDLE) && (phase != PH_SKIP);

   always_ff @(posedge clk) begin
      if (!por_n) begin
         phase   <= PH_IDLE;
         bit_cnt <= '0;
         in_ack  <= 1'b0;
         ack_drv <= 1'b0;
         shreg   <= '0;
         idx     <= '0;
         wr_en   <= 1'b0;
         wr_idx  <= '0;
         wr_data <= '0;
      end else begin
         wr_en <= 1'b0;
         if (bus_start) begin
            phase   <= PH_ADDR;
            bit_cnt <= '0;
            in_ack  <= 1'b0;
            ack_drv <= 1'b0;
            idx     <= '0;
         end else if (bus_stop) begin
            phase   <= PH_IDLE;
            bit_cnt <= '0;
            in_ack  <= 1'b0;
            ack_drv <= 1'b0;
         end else if (active) begin
            if (scl_rise && !in_ack && bit_cnt != 4'd8) begin
               shreg   <= {shreg[BYTE_BITS-2:0], sda_s};
               bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall && in_ack) begin
               in_ack  <= 1'b0;
               ack_drv <= 1'b0;
               bit_cnt <= '0;
            end else if (scl_fall && bit_cnt == 4'd8) begin
               in_ack  <= 1'b1;
               ack_drv <= 1'b1;
               unique case (phase)
                  PH_ADDR: begin
                     if (shreg[BYTE_BITS-1:1] == DEV_ADDR && !shreg[0]) begin
                        phase <= PH_CMD;
                     end else begin
                        phase   <= PH_SKIP;
                        in_ack  <= 1'b0;
                        ack_drv <= 1'b0;
                     end
                  end
                  PH_CMD:   phase <= PH_COUNT;
                  PH_COUNT: phase <= PH_DATA;
                  PH_DATA: begin
                     if (idx != IDX_END) begin
                        wr_en   <= 1'b1;
                        wr_idx  <= idx;
                        wr_data <= shreg;
                        idx     <= idx + 1'b1;
                     end
                  end
                  default: ;
               endcase
            end
         end
      end
   end

   p_ack_on_fall_r11: assert property (@(posedge clk) disable iff (!por_n)
      $rose(ack_drv) |-> $past(scl_fall));
   p_ack_release_r11: assert property (@(posedge clk) disable iff (!por_n)
      $fell(ack_drv) |-> $past(scl_fall || bus_start || bus_stop));
   p_index_restart_r8: assert property (@(posedge clk) disable iff (!por_n)
      bus_start |=> (idx == '0));
endmodule

// File: rtl/clkcfg_reg_bank.sv
module clkcfg_reg_bank
   import clkcfg_pkg::*;
#(
   parameter int NUM_REGS = 6,
   parameter int IDX_W    = $clog2(NUM_REGS + 1),
   parameter int STRAP_W  = 3,
   parameter logic [BYTE_BITS*NUM_REGS-1:0] RESET_VALUE = '0
) (
   input  logic                          clk,
   input  logic                          por_n,
   input  logic                          wr_en,
   input  logic [IDX_W-1:0]              wr_idx,
   input  logic [BYTE_BITS-1:0]          wr_data,
   input  logic [STRAP_W-1:0]            strap_i,
   output logic [STRAP_W-1:0]            strap_q,
   output logic [BYTE_BITS*NUM_REGS-1:0] cfg_regs
);
   logic [BYTE_BITS-1:0] bank [NUM_REGS];

   generate
      for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
         always_ff @(posedge clk) begin
            if (!por_n)
               bank[r] <= RESET_VALUE[r*BYTE_BITS +: BYTE_BITS];
            else if (wr_en && wr_idx == IDX_W'(r))
               bank[r] <= wr_data;
         end
         assign cfg_regs[r*BYTE_BITS +: BYTE_BITS] = bank[r];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!por_n) strap_q <= strap_i;
   end

   p_hold_without_write_r3: assert property (@(posedge clk) disable iff (!por_n)
      !wr_en |=> $stable(cfg_regs));
   p_write_lands_r6: assert property (@(posedge clk) disable iff (!por_n)
      wr_en |=> cfg_regs[$past(wr_idx)*BYTE_BITS +: BYTE_BITS] == $past(wr_data));
   p_strap_frozen_r10: assert property (@(posedge clk) disable iff (!por_n)
      por_n |=> $stable(strap_q));
endmodule

// File: rtl/clkcfg_i2c_target.sv
module clkcfg_i2c_target
   import clkcfg_pkg::*;
#(
   parameter logic [ADDR_BITS-1:0] DEV_ADDR = 7'h69,
   parameter int NUM_REGS    = 6,
   parameter int STRAP_W     = 3,
   parameter int SYNC_STAGES = 2,
   parameter logic [BYTE_BITS*NUM_REGS-1:0] RESET_VALUE = 48'h0F_FF_FF_3E_FF_A5
) (
   input  logic                          clk,
   input  logic                          por_n,
   input  logic                          scl_i,
   input  logic                          sda_i,
   output logic                          sda_o,
   output logic                          sda_oe,
   input  logic [STRAP_W-1:0]            strap_i,
   output logic [STRAP_W-1:0]            strap_q,
   output logic [BYTE_BITS*NUM_REGS-1:0] cfg_regs
);
   localparam int IDX_W = $clog2(NUM_REGS + 1);

   generate
      if (NUM_REGS < 1) begin : g_bad_regs
         $error("clkcfg_i2c_target: NUM_REGS must be at least 1");
      end
      if (STRAP_W < 1) begin : g_bad_strap
         $error("clkcfg_i2c_target: STRAP_W must be at least 1");
      end
   endgenerate

   logic                 sda_s, scl_rise, scl_fall, bus_start, bus_stop;
   logic                 wr_en;
   logic [IDX_W-1:0]     wr_idx;
   logic [BYTE_BITS-1:0] wr_data;

   clkcfg_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .por_n(por_n), .scl_i(scl_i), .sda_i(sda_i),
      .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .bus_start(bus_start), .bus_stop(bus_stop)
   );

   clkcfg_byte_engine #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_engine (
      .clk(clk), .por_n(por_n), .sda_s(sda_s), .scl_rise(scl_rise),
      .scl_fall(scl_fall), .bus_start(bus_start), .bus_stop(bus_stop),
      .ack_drv(sda_oe), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
   );

   clkcfg_reg_bank #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .STRAP_W(STRAP_W),
                     .RESET_VALUE(RESET_VALUE)) u_bank (
      .clk(clk), .por_n(por_n), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_data(wr_data), .strap_i(strap_i), .strap_q(strap_q),
      .cfg_regs(cfg_regs)
   );

   assign sda_o = 1'b0;

   p_quiet_in_reset_r1: assert property (@(posedge clk)
      !por_n |=> !sda_oe);
endmodule

// File: tb/clkcfg_i2c_target_bench.sv
module clkcfg_i2c_target_bench;
   localparam logic [6:0]  DEV = 7'h69;
   localparam int          NR  = 6;
   localparam logic [47:0] RV  = 48'h0F_FF_FF_3E_FF_A5;
   localparam int          Q   = 8;
   localparam int          H   = 16;

   logic          clk = 1'b0;
   logic          por_n = 1'b0;
   logic          m_scl = 1'b1, m_sda = 1'b1;
   logic          sda_line, sda_o, sda_oe;
   logic [2:0]    strap_i = 3'b010;
   logic [2:0]    strap_q;
   logic [8*NR-1:0] cfg_regs;

   int            n_chk = 0, n_fail = 0;
   logic [7:0]    exp_reg [NR];
   logic [7:0]    dbuf [16];
   logic          oe_bad;

   always #10 clk = ~clk;
   assign sda_line = m_sda & ~(sda_oe & ~sda_o);

   clkcfg_i2c_target #(.DEV_ADDR(DEV), .NUM_REGS(NR), .RESET_VALUE(RV)) u_clkcfg_i2c_target (
      .clk(clk), .por_n(por_n), .scl_i(m_scl), .sda_i(sda_line),
      .sda_o(sda_o), .sda_oe(sda_oe), .strap_i(strap_i), .strap_q(strap_q),
      .cfg_regs(cfg_regs)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(H);
      m_sda = 1'b0; tick(H); m_scl = 1'b0; tick(Q);
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; tick(Q); m_scl = 1'b1; tick(H); m_sda = 1'b1; tick(H);
   endtask

   task automatic send_bits(input logic [7:0] b, input int n);
      for (int i = 7; i > 7 - n; i--) begin
         m_sda = b[i]; tick(Q); m_scl = 1'b1; tick(H/2);
         if (sda_oe) oe_bad = 1'b1;
         tick(H/2); m_scl = 1'b0; tick(Q);
      end
   endtask

   task automatic send_byte(input logic [7:0] b, output bit acked);
      send_bits(b, 8);
      m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(H/2);
      acked = sda_oe;
      tick(H/2); m_scl = 1'b0; tick(Q);
   endtask

   function automatic bit addr_ok(input logic [6:0] a, input bit rw);
      return (a == DEV) && !rw;
   endfunction

   task automatic check_regs(input string req);
      for (int k = 0; k < NR; k++)
         chk(cfg_regs[k*8 +: 8] == exp_reg[k], req, $sformatf("reg%0d", k),
             cfg_regs[k*8 +: 8], exp_reg[k]);
   endtask

   // full framed write: address, command, count, n data bytes from dbuf, then STOP
   task automatic write_txn(input logic [6:0] a, input bit rw, input logic [7:0] cmd,
                            input logic [7:0] cnt, input int n);
      bit ack, exp_ack, all_ok;
      oe_bad = 1'b0;
      exp_ack = addr_ok(a, rw);
      bus_start();
      send_byte({a, rw}, ack);
      if (exp_ack) chk(ack == 1'b1, "R2", "address ack", ack, 1);
      else         chk(ack == 1'b0, "R3", "address nack", ack, 0);
      all_ok = 1'b1;
      send_byte(cmd, ack); if (ack != exp_ack) all_ok = 1'b0;
      send_byte(cnt, ack); if (ack != exp_ack) all_ok = 1'b0;
      chk(all_ok, "R4 R5", "command/count ack", all_ok, 1);
      all_ok = 1'b1;
      for (int k = 0; k < n; k++) begin
         send_byte(dbuf[k], ack);
         if (ack != exp_ack) all_ok = 1'b0;
         if (exp_ack && k < NR) exp_reg[k] = dbuf[k];
      end
      chk(all_ok, "R7", "data byte acks", all_ok, 1);
      chk(!oe_bad, "R11", "sda_oe low in data bits", oe_bad, 0);
      bus_stop();
      tick(4);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      chk(1'b0, "WD", "watchdog expired", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      bit ack;
      int unused_seed;
      unused_seed = $urandom(32'h5EED_1234);
      for (int k = 0; k < NR; k++) exp_reg[k] = RV[k*8 +: 8];
      tick(3);
      chk(sda_oe == 1'b0, "R1", "sda_oe in reset", sda_oe, 0);
      tick(7);
      por_n = 1'b1;
      tick(2);
      strap_i = 3'b101;
      check_regs("R1");
      chk(sda_oe == 1'b0, "R1", "sda_oe after reset", sda_oe, 0);
      tick(20);
      chk(strap_q == 3'b010, "R10", "strap latch frozen", strap_q, 3'b010);

      // R6: ordered fill of three registers
      dbuf[0] = 8'h11; dbuf[1] = 8'h22; dbuf[2] = 8'h33;
      write_txn(DEV, 1'b0, 8'hA5, 8'h03, 3);
      check_regs("R6");

      // R3: wrong address, then read bit set
      dbuf[0] = 8'hEE; dbuf[1] = 8'hDD;
      write_txn(DEV ^ 7'h01, 1'b0, 8'h00, 8'h02, 2);
      check_regs("R3");
      write_txn(DEV, 1'b1, 8'h00, 8'h02, 2);
      check_regs("R3");

      // R7: two bytes past the bank end
      for (int k = 0; k < NR + 2; k++) dbuf[k] = 8'h40 + 8'(k);
      write_txn(DEV, 1'b0, 8'hFF, 8'hFF, NR + 2);
      check_regs("R7");

      // R9: STOP in mid byte after one full data byte
      bus_start();
      send_byte({DEV, 1'b0}, ack); send_byte(8'h00, ack); send_byte(8'h00, ack);
      send_byte(8'h9C, ack); exp_reg[0] = 8'h9C;
      send_bits(8'h5A, 4);
      bus_stop(); tick(4);
      check_regs("R9");

      // R8/R9: START in mid byte, then repeated START restarts at register 0
      bus_start();
      send_byte({DEV, 1'b0}, ack); send_byte(8'h00, ack); send_byte(8'h00, ack);
      send_byte(8'h71, ack); exp_reg[0] = 8'h71;
      send_bits(8'hC3, 3);
      bus_start();
      send_byte({DEV, 1'b0}, ack); send_byte(8'h00, ack); send_byte(8'h00, ack);
      send_byte(8'h2B, ack); exp_reg[0] = 8'h2B;
      chk(ack == 1'b1, "R8", "data ack after repeated start", ack, 1);
      bus_stop(); tick(4);
      check_regs("R8");

      // random transactions
      for (int t = 0; t < 18; t++) begin
         logic [6:0] a;
         bit         rw;
         int         n;
         a  = ($urandom_range(0, 3) == 0) ? 7'($urandom) : DEV;
         rw = ($urandom_range(0, 5) == 0);
         n  = $urandom_range(0, NR + 2);
         for (int k = 0; k < n; k++) dbuf[k] = 8'($urandom);
         write_txn(a, rw, 8'($urandom), 8'($urandom), n);
         check_regs("R6");
      end

      chk(strap_q == 3'b010, "R10", "strap latch at end", strap_q, 3'b010);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule